// File: doc/BRIEF.md
# Serial Frame Transmitter with Internal Loopback

This block turns parallel words into asynchronous serial frames on a transmit pad. A software-visible 16-bit control word picks the frame length (ten or eleven bits), whether a parity bit is sent and its sense, whether the pad behaves as an open-drain driver, and whether the serial stream is routed back to an internal receive input for self-test. Words enter a holding register and move from there into a shift register. The holding register can take the next word while the current frame is still being shifted out.

Bit timing comes from an external baud-tick strobe: every bit lasts sixteen ticks. Two status flags track progress. One says the holding register can take a word. The other says the line has gone idle with nothing queued. Each flag has its own interrupt enable. While the transmitter is switched off, the pad carries a general-purpose level supplied by the system.

Top module: `sci_tx_loop`

## Requirements
- R1: After reset the control word is all zeros, `tdre` and `tc` are 1, both interrupt outputs are 0, and the pad actively drives the value of `gp_out` (`txd_oe`=1, `txd_o`=`gp_out`).
- R2: Control word bits are: bit0 transmitter on, bit1 loopback, bit2 open-drain, bit3 parity on, bit4 odd parity, bit5 long frame, bit6 empty-interrupt enable, bit7 complete-interrupt enable. Bits 15:8 have no effect. With bit5=0 a frame is a 0 start bit, then `wr_data[7:0]` LSB first, then one 1 stop bit (10 bits), and `wr_data[8]` is not sent.
- R3: With bit5=1 a frame carries nine data bits, `wr_data[8:0]` LSB first, between start and stop (11 bits).
- R4: With parity on, the last data slot of the frame (data bit 7 in a short frame, bit 8 in a long one) carries a parity bit instead. That bit makes the count of ones over the remaining data bits plus the parity bit even when bit4=0, or odd when bit4=1.
- R5: Every frame bit stays on the line for exactly 16 `baud_tick` pulses, whatever spacing the pulses have.
- R6: A write (`wr_en`) clears `tdre` on the next edge. `tdre` sets again on the edge at which the held word moves to the shift register, which is the edge after the write when the shifter is idle and the transmitter is on. `tx_irq` equals `tdre` AND bit6.
- R7: A write clears `tc`. `tc` sets when a stop bit ends and no word is held. `tc_irq` equals `tc` AND bit7.
- R8: A word written while a frame is in flight starts after that frame's stop bit with a single idle cycle between them, and `tc` stays 0 across the handover.
- R9: With bit0=0 the pad shows `gp_out`, any frame in progress is dropped, and a written word stays held (`tdre`=0) until the transmitter is switched on, at which point it is sent.
- R10: With bit2=1 the pad never drives high: a 0 level gives `txd_oe`=1 with `txd_o`=0, and a 1 level gives `txd_oe`=0.
- R11: With bit1=1 `loop_rx` follows the level on the pad (transmitted bit, or `gp_out` when off). With bit1=0 `loop_rx` equals `rx_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_we | input | 1 | Load the control word |
| ctrl_wdata | input | 16 | New control word |
| wr_en | input | 1 | Write a word into the holding register |
| wr_data | input | 9 | Word to transmit |
| baud_tick | input | 1 | Oversampling tick, sixteen per bit |
| gp_out | input | 1 | Level for the pad while the transmitter is off |
| rx_pin | input | 1 | External receive pin, passed to `loop_rx` when not looping |
| txd_o | output | 1 | Pad output value |
| txd_oe | output | 1 | Pad output enable |
| loop_rx | output | 1 | Receive input for the receiver |
| tdre | output | 1 | Holding register empty |
| tc | output | 1 | Transmission complete |
| tx_irq | output | 1 | Empty-flag interrupt request |
| tc_irq | output | 1 | Complete-flag interrupt request |

## Verification
Frames are captured bit by bit at mid-bit and compared against frames built from the requirement text. The stimulus covers both frame lengths, with parity off, even and odd. It also includes data whose ninth bit is set in short-frame mode and a control word with every upper bit set, which separates correct field decoding from slot misplacement and parity-sense errors. Open-drain and loopback runs capture the same frames through the pad enable and through `loop_rx`, to show the level reaches each path intact. Directed runs with sparse ticks, back-to-back writes and a disabled transmitter separate correct bit length, handover and hold-off from off-by-one tick counts and premature flag setting.

// File: rtl/sci_tx_pkg.sv
package sci_tx_pkg;

    localparam int CW        = 16;              // control word width
    localparam int DATA_MAX  = 9;               // widest payload (long frame)
    localparam int FRAME_MAX = DATA_MAX + 2;    // start + payload + stop
    localparam int LEN_W     = $clog2(FRAME_MAX + 1);
    localparam int OVS       = 16;              // ticks per bit

    // Low byte of the control word; upper byte has no function.
    typedef struct packed {
        logic done_ie;     // bit7
        logic empty_ie;    // bit6
        logic frame_long;  // bit5
        logic par_odd;     // bit4
        logic par_en;      // bit3
        logic open_drain;  // bit2
        logic loop_en;     // bit1
        logic tx_en;       // bit0
    } sci_ctrl_t;

    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;  // LSB goes out first
        logic [LEN_W-1:0]     len;
    } sci_frame_t;

    // Assemble the serial image of one word under the given settings.
    function automatic logic [FRAME_MAX-1:0] build_frame(
        input logic [DATA_MAX-1:0] d,
        input sci_ctrl_t           c
    );
        logic [FRAME_MAX-1:0] f;
        logic                 p;
        int                   n;
        n    = c.frame_long ? DATA_MAX : DATA_MAX - 1;
        p    = c.par_odd;
        f    = '1;
        f[0] = 1'b0;
        for (int i = 0; i < DATA_MAX; i++) begin
            if (i < n) begin
                f[i+1] = d[i];
                if (i < n - 1) p = p ^ d[i];
            end
        end
        if (c.par_en) f[n] = p;
        return f;
    endfunction

    function automatic logic [LEN_W-1:0] frame_len(input sci_ctrl_t c);
        return c.frame_long ? LEN_W'(FRAME_MAX) : LEN_W'(FRAME_MAX - 1);
    endfunction

endpackage

// File: rtl/sci_tx_bitclk.sv
module sci_tx_bitclk #(
    parameter int TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic baud_tick,
    output logic bit_end
);
    localparam int CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic             last_tick;

    assign last_tick = (cnt_q == CNT_W'(TICKS - 1));
    assign bit_end   = run && baud_tick && last_tick;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (baud_tick) begin
            cnt_q <= last_tick ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sci_tx_holding.sv
module sci_tx_holding
    import sci_tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [DATA_MAX-1:0] wr_data,
    input  logic                take,
    input  logic                frame_done,
    output logic [DATA_MAX-1:0] hold_data,
    output logic                hold_full,
    output logic                tdre,
    output logic                tc
);
    logic tc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_data <= '0;
            hold_full <= 1'b0;
        end else if (wr_en) begin
            hold_data <= wr_data;
            hold_full <= 1'b1;
        end else if (take) begin
            hold_full <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tc_q <= 1'b1;
        end else if (wr_en) begin
            tc_q <= 1'b0;
        end else if (frame_done && !hold_full) begin
            tc_q <= 1'b1;
        end
    end

    assign tdre = !hold_full;
    assign tc   = tc_q;

    // R6
    tdre_clr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !tdre);

    // R6
    tdre_set_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !wr_en) |=> tdre);

    // R7
    tc_set_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !hold_full && !wr_en) |=> tc);

    // R7
    tc_clr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !tc);

endmodule

// File: rtl/sci_tx_shifter.sv
module sci_tx_shifter
    import sci_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       load,
    input  sci_frame_t frame_in,
    input  logic       bit_end,
    output logic       busy,
    output logic       ser,
    output logic       frame_done
);
    logic [FRAME_MAX-1:0] sreg_q;
    logic [LEN_W-1:0]     left_q;

    assign frame_done = bit_end && (left_q == LEN_W'(1));
    assign ser        = sreg_q[0];

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            sreg_q <= '1;
            left_q <= '0;
            busy   <= 1'b0;
        end else if (load) begin
            sreg_q <= frame_in.bits;
            left_q <= frame_in.len;
            busy   <= 1'b1;
        end else if (bit_end) begin
            sreg_q <= {1'b1, sreg_q[FRAME_MAX-1:1]};
            left_q <= left_q - 1'b1;
            if (left_q == LEN_W'(1)) busy <= 1'b0;
        end
    end

    // R2
    start_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (load && enable) |=> (!enable || (busy && !ser)));

    // R2
    stop_bit_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> ser);

    // R5
    bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !bit_end && !load) |=> (!enable || $stable(ser)));

endmodule

// File: rtl/sci_tx_pad.sv
module sci_tx_pad (
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    input  logic open_drain,
    input  logic loop_en,
    input  logic ser,
    input  logic gp_out,
    input  logic rx_pin,
    output logic txd_o,
    output logic txd_oe,
    output logic loop_rx
);
    logic line;

    assign line = tx_en ? ser : gp_out;

    always_comb begin
        if (open_drain) begin
            txd_o  = 1'b0;
            txd_oe = !line;
        end else begin
            txd_o  = line;
            txd_oe = 1'b1;
        end
    end

    assign loop_rx = loop_en ? line : rx_pin;

    // R10
    od_high_chk: assert property (@(posedge clk) disable iff (rst)
        open_drain |-> !(txd_oe && txd_o));

    // R11
    loop_follow_chk: assert property (@(posedge clk) disable iff (rst)
        loop_en |-> (loop_rx == (txd_oe ? txd_o : 1'b1)));

endmodule

// File: rtl/sci_tx_loop.sv
module sci_tx_loop
    import sci_tx_pkg::*;
#(
    parameter int TICKS_PER_BIT = OVS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ctrl_we,
    input  logic [CW-1:0]       ctrl_wdata,
    input  logic                wr_en,
    input  logic [DATA_MAX-1:0] wr_data,
    input  logic                baud_tick,
    input  logic                gp_out,
    input  logic                rx_pin,
    output logic                txd_o,
    output logic                txd_oe,
    output logic                loop_rx,
    output logic                tdre,
    output logic                tc,
    output logic                tx_irq,
    output logic                tc_irq
);
    sci_ctrl_t           ctrl_q;
    logic [CW-9:0]       ctrl_unused;
    logic [DATA_MAX-1:0] hold_data;
    logic                hold_full;
    logic                busy;
    logic                take;
    logic                bit_end;
    logic                ser;
    logic                frame_done;
    sci_frame_t          frame;

    assign ctrl_unused = ctrl_wdata[CW-1:8];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_we) begin
            ctrl_q <= sci_ctrl_t'(ctrl_wdata[7:0]);
        end
    end

    assign take       = hold_full && !busy && ctrl_q.tx_en;
    assign frame.bits = build_frame(hold_data, ctrl_q);
    assign frame.len  = frame_len(ctrl_q);

    sci_tx_holding u_hold (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .take       (take),
        .frame_done (frame_done),
        .hold_data  (hold_data),
        .hold_full  (hold_full),
        .tdre       (tdre),
        .tc         (tc)
    );

    sci_tx_bitclk #(.TICKS(TICKS_PER_BIT)) u_bitclk (
        .clk       (clk),
        .rst       (rst),
        .run       (busy),
        .baud_tick (baud_tick),
        .bit_end   (bit_end)
    );

    sci_tx_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .enable     (ctrl_q.tx_en),
        .load       (take),
        .frame_in   (frame),
        .bit_end    (bit_end),
        .busy       (busy),
        .ser        (ser),
        .frame_done (frame_done)
    );

    sci_tx_pad u_pad (
        .clk        (clk),
        .rst        (rst),
        .tx_en      (ctrl_q.tx_en),
        .open_drain (ctrl_q.open_drain),
        .loop_en    (ctrl_q.loop_en),
        .ser        (ser),
        .gp_out     (gp_out),
        .rx_pin     (rx_pin),
        .txd_o      (txd_o),
        .txd_oe     (txd_oe),
        .loop_rx    (loop_rx)
    );

    assign tx_irq = tdre && ctrl_q.empty_ie;
    assign tc_irq = tc && ctrl_q.done_ie;

    // R9
    dis_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.tx_en |=> !busy);

    // R8
    no_gap_tc_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_done && hold_full) |=> (!tc && take));

endmodule

// File: tb/sci_tx_loop_bench.sv
module sci_tx_loop_bench;
    localparam time CLK_P = 10ns;
    localparam int  NVEC  = 10;

    // {control word, data}
    localparam logic [24:0] VEC [NVEC] = '{
        {16'h0001, 9'h0A5},   // R2 short, no parity
        {16'h0001, 9'h1C3},   // R2 bit 8 not sent
        {16'hFF01, 9'h03C},   // R2 upper control bits ignored
        {16'h0009, 9'h035},   // R4 even
        {16'h0019, 9'h035},   // R4 odd
        {16'h0021, 9'h1A5},   // R3 long
        {16'h0029, 9'h0C3},   // R3 R4 long even
        {16'h0039, 9'h0FF},   // R3 R4 long odd
        {16'h0005, 9'h05A},   // R10 open drain
        {16'h0003, 9'h13C}    // R11 loopback
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_we = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_data = '0;
    logic        baud_tick = 1'b1;
    logic        gp_out = 1'b0;
    logic        rx_pin = 1'b0;
    logic        txd_o, txd_oe, loop_rx, tdre, tc, tx_irq, tc_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    sci_tx_loop u_sci_tx_loop (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .wr_en(wr_en), .wr_data(wr_data), .baud_tick(baud_tick),
        .gp_out(gp_out), .rx_pin(rx_pin), .txd_o(txd_o), .txd_oe(txd_oe),
        .loop_rx(loop_rx), .tdre(tdre), .tc(tc), .tx_irq(tx_irq), .tc_irq(tc_irq)
    );

    function automatic logic pad_lvl();
        return txd_oe ? txd_o : 1'b1;
    endfunction

    function automatic int exp_len(input logic [15:0] c);
        return c[5] ? 11 : 10;
    endfunction

    function automatic logic [10:0] exp_frame(input logic [15:0] c, input logic [8:0] d);
        logic [10:0] f;
        logic        p;
        int          n;
        n = c[5] ? 9 : 8;
        f = '1;
        f[0] = 1'b0;
        p = c[4];
        for (int i = 0; i < n; i++) f[i+1] = d[i];
        for (int i = 0; i < n - 1; i++) p = p ^ d[i];
        if (c[3]) f[n] = p;
        return f;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
        end
    endtask

    task automatic set_ctrl(input logic [15:0] v);
        @(negedge clk);
        ctrl_we = 1'b1;
        ctrl_wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic put_word(input logic [8:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic capture(input bit use_loop, input bit od, input int len,
                           output logic [10:0] got, output bit od_ok);
        int   guard;
        logic b;
        guard = 0;
        od_ok = 1'b1;
        got   = '1;
        while (((use_loop ? loop_rx : pad_lvl()) != 1'b0) && guard < 400) begin
            @(negedge clk);
            guard++;
        end
        repeat (8) @(negedge clk);
        for (int k = 0; k < len; k++) begin
            b = use_loop ? loop_rx : pad_lvl();
            got[k] = b;
            if (od && !((b && !txd_oe) || (!b && txd_oe && !txd_o))) od_ok = 1'b0;
            if (k < len - 1) repeat (16) @(negedge clk);
        end
    endtask

    initial begin
        logic [10:0] got;
        logic [10:0] expf;
        bit          od_ok;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(tdre == 1'b1 && tc == 1'b1, "R1 flags", {tdre, tc}, 2'b11);
        check(!tx_irq && !tc_irq, "R1 irqs", {tx_irq, tc_irq}, 0);
        check(txd_oe && !txd_o, "R1 pad gp0", {txd_oe, txd_o}, 2'b10);
        gp_out = 1'b1;
        @(negedge clk);
        check(txd_oe && txd_o, "R1 pad gp1", {txd_oe, txd_o}, 2'b11);

        // vector table: R2 R3 R4 R10 R11
        for (int v = 0; v < NVEC; v++) begin
            logic [15:0] c;
            logic [8:0]  d;
            c = VEC[v][24:9];
            d = VEC[v][8:0];
            set_ctrl(c);
            put_word(d);
            capture(c[1], c[2], exp_len(c), got, od_ok);
            expf = exp_frame(c, d);
            check(got == expf, c[1] ? "R11 loop frame" : (c[5] ? "R3 frame" : "R2/R4 frame"), got, expf);
            if (c[2]) check(od_ok, "R10 open drain levels", od_ok, 1);
            repeat (10) @(negedge clk);
            check(tc && tdre, "R7 end flags", {tc, tdre}, 2'b11);
        end

        // R6 empty flag timing and interrupt
        set_ctrl(16'h0041);
        put_word(9'h055);
        check(!tdre && !tx_irq, "R6 tdre cleared", {tdre, tx_irq}, 0);
        check(!tc, "R7 tc cleared by write", tc, 0);
        @(negedge clk);
        check(tdre && tx_irq, "R6 tdre set on transfer", {tdre, tx_irq}, 2'b11);
        set_ctrl(16'h0081);
        check(!tc_irq, "R7 tc_irq low mid frame", tc_irq, 0);
        repeat (170) @(negedge clk);
        check(tc && tc_irq, "R7 tc_irq after stop", {tc, tc_irq}, 2'b11);

        // R8 back to back
        set_ctrl(16'h0001);
        put_word(9'h0F0);
        @(negedge clk);
        put_word(9'h00F);
        check(!tdre, "R8 second word held", tdre, 0);
        capture(1'b0, 1'b0, 10, got, od_ok);
        expf = exp_frame(16'h0001, 9'h0F0);
        check(got == expf, "R8 first frame", got, expf);
        repeat (8) @(negedge clk);
        check(!tc && tdre, "R8 tc low at handover", {tc, tdre}, 2'b01);
        capture(1'b0, 1'b0, 10, got, od_ok);
        expf = exp_frame(16'h0001, 9'h00F);
        check(got == expf, "R8 second frame", got, expf);
        repeat (12) @(negedge clk);
        check(tc, "R8 tc after last frame", tc, 1);

        // R5 sparse ticks: start bit spans 16 ticks
        @(negedge clk);
        baud_tick = 1'b0;
        put_word(9'h001);
        @(negedge clk);
        check(pad_lvl() == 1'b0, "R5 start visible", pad_lvl(), 0);
        for (int t = 0; t < 15; t++) begin
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
            @(negedge clk);
        end
        check(pad_lvl() == 1'b0, "R5 start after 15 ticks", pad_lvl(), 0);
        baud_tick = 1'b1;
        @(negedge clk);
        baud_tick = 1'b0;
        check(pad_lvl() == 1'b1, "R5 data bit after 16 ticks", pad_lvl(), 1);
        baud_tick = 1'b1;
        repeat (180) @(negedge clk);

        // R9 transmitter off
        set_ctrl(16'h0000);
        gp_out = 1'b1;
        put_word(9'h0F3);
        repeat (40) @(negedge clk);
        check(txd_oe && txd_o, "R9 pad gp1", {txd_oe, txd_o}, 2'b11);
        check(!tdre, "R9 word held", tdre, 0);
        gp_out = 1'b0;
        @(negedge clk);
        check(txd_oe && !txd_o, "R9 pad gp0", {txd_oe, txd_o}, 2'b10);
        set_ctrl(16'h0001);
        capture(1'b0, 1'b0, 10, got, od_ok);
        expf = exp_frame(16'h0001, 9'h0F3);
        check(got == expf, "R9 held word sent", got, expf);
        repeat (12) @(negedge clk);
        put_word(9'h000);
        repeat (30) @(negedge clk);
        gp_out = 1'b1;
        set_ctrl(16'h0000);
        check(pad_lvl() == 1'b1, "R9 frame dropped", pad_lvl(), 1);
        set_ctrl(16'h0001);
        repeat (3) @(negedge clk);
        check(pad_lvl() == 1'b1 && tdre, "R9 no resume", {pad_lvl(), tdre}, 2'b11);

        // R10 idle open drain, R11 path select
        set_ctrl(16'h0005);
        @(negedge clk);
        check(!txd_oe, "R10 idle released", txd_oe, 0);
        set_ctrl(16'h0004);
        gp_out = 1'b0;
        @(negedge clk);
        check(txd_oe && !txd_o, "R10 gp low drives", {txd_oe, txd_o}, 2'b10);
        set_ctrl(16'h0001);
        rx_pin = 1'b0;
        @(negedge clk);
        check(loop_rx == 1'b0, "R11 pin path 0", loop_rx, 0);
        rx_pin = 1'b1;
        @(negedge clk);
        check(loop_rx == 1'b1, "R11 pin path 1", loop_rx, 1);
        set_ctrl(16'h0003);
        rx_pin = 1'b0;
        @(negedge clk);
        check(loop_rx == 1'b1, "R11 loop ignores pin", loop_rx, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule